// File: doc/BRIEF.md
# BCD Calendar Alarm Comparator

This block stores an alarm instant as six BCD bytes, arranged the same way as the calendar value that a companion time counter drives into it. On every seconds-increment strobe from that counter, the block compares all six alarm bytes with the live calendar. When every byte matches, it sets a sticky alarm flag.

The alarm line is a level output that is active low. It is asserted only while the alarm flag and the alarm interrupt enable are both 1. The flag is set on a match even when the interrupt is disabled, so software can still see the event by reading the status register.

Software reaches the block through a simple byte-addressed register port. Reads are combinational from the address, and writes take effect on the clock edge. Software acknowledges a pending alarm by writing the status value it has just read back to the status register, because a 1 written to the flag bit clears it.

The usual sequence to re-arm the alarm is:
- write 0 to the enable register,
- rewrite the six alarm bytes,
- set the enable bit again.

Top module: `alarm_cmp_top`

## Requirements
- R1: After reset, all six alarm bytes read 0x00, the enable and status registers read 0x00, and irq_n is 1.
- R2: Addresses 0 to 5 hold the alarm bytes in the order seconds, minutes, hours, day, month, year. Each is written whole and reads back the value written. The calendar input uses the same order, with seconds in bits [7:0] and year in bits [47:40].
- R3: At a clock edge where sec_tick is 1 and all six calendar bytes equal the alarm bytes, status bit 0 becomes 1.
- R4: The flag is not set if sec_tick is 0, or if any single byte differs. This includes a month of 0x12 against 0x11 and a year of 0x99 against 0x98.
- R5: The flag is set on a match even while the enable bit is 0, and irq_n then stays 1.
- R6: irq_n is 0 exactly while status bit 0 and enable bit 0 are both 1. It stays 0 at the level, with no further sec_tick, until one of the two bits drops.
- R7: Writing status (address 7) with bit 0 at 1 clears the flag. Writing it with bit 0 at 0 leaves the flag unchanged.
- R8: When a match and a clearing status write occur at the same edge, the flag ends at 1.
- R9: Address 6 holds the enable in bit 0. Writing 0 there releases irq_n to 1 while the flag stays set, and writing 1 arms the interrupt again.
- R10: Reads of addresses 8 to 15 return 0x00, and writes to them change no register. Bits 7:1 of the enable and status registers read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sec_tick | input | 1 | One-cycle strobe from the counter when the seconds value advances |
| cal_time | input | 48 | Live calendar, six BCD bytes, seconds in the lowest byte |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register byte address for reads and writes |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for addr (combinational) |
| irq_n | output | 1 | Alarm interrupt, level, active low |

## Verification
The hardest situation to reach from the ports is a clearing status write that lands on the same edge as a matching seconds strobe. The bench drives both in one cycle with the calendar already equal to the alarm, then reads status back to confirm that the set won. Near-miss matches are reached by sweeping a one-byte difference across each of the six positions in turn, including the month and year upper limits. Enable and flag are toggled in every order so that the level gating of irq_n is observed in each combination.

// File: rtl/alarm_cmp_pkg.sv
package alarm_cmp_pkg;
   localparam int unsigned BCD_DIGIT_W = 4;

   typedef enum logic [1:0] {
      SEL_ALARM  = 2'd0,
      SEL_ENABLE = 2'd1,
      SEL_STATUS = 2'd2,
      SEL_NONE   = 2'd3
   } reg_sel_e;
endpackage

// File: rtl/alarm_cmp_regs.sv
module alarm_cmp_regs #(
   parameter int unsigned NUM_FIELDS = 6,
   parameter int unsigned FIELD_W    = 8
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic [NUM_FIELDS-1:0]           field_we,
   input  logic                            en_we,
   input  logic [FIELD_W-1:0]              wr_data,
   output logic [NUM_FIELDS*FIELD_W-1:0]   alarm_flat,
   output logic                            irq_en
);
   genvar gi;
   generate
      for (gi = 0; gi < NUM_FIELDS; gi++) begin : g_field
         logic [FIELD_W-1:0] field_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)            field_q <= '0;
            else if (field_we[gi]) field_q <= wr_data;
         end
         assign alarm_flat[gi*FIELD_W +: FIELD_W] = field_q;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     irq_en <= 1'b0;
      else if (en_we) irq_en <= wr_data[0];
   end
endmodule

// File: rtl/alarm_cmp_match.sv
module alarm_cmp_match #(
   parameter int unsigned NUM_FIELDS = 6,
   parameter int unsigned FIELD_W    = 8
) (
   input  logic [NUM_FIELDS*FIELD_W-1:0] alarm_flat,
   input  logic [NUM_FIELDS*FIELD_W-1:0] cal_flat,
   output logic                          all_eq
);
   logic [NUM_FIELDS-1:0] field_eq;

   genvar gi;
   generate
      for (gi = 0; gi < NUM_FIELDS; gi++) begin : g_cmp
         assign field_eq[gi] =
            (alarm_flat[gi*FIELD_W +: FIELD_W] == cal_flat[gi*FIELD_W +: FIELD_W]);
      end
   endgenerate

   assign all_eq = &field_eq;
endmodule

// File: rtl/alarm_cmp_status.sv
module alarm_cmp_status (
   input  logic clk,
   input  logic rst_n,
   input  logic set_ev,
   input  logic clr_ev,
   input  logic irq_en,
   output logic flag,
   output logic irq_n
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      flag <= 1'b0;
      else if (set_ev) flag <= 1'b1;
      else if (clr_ev) flag <= 1'b0;
   end

   assign irq_n = ~(flag & irq_en);
endmodule

// File: rtl/alarm_cmp_top.sv
module alarm_cmp_top #(
   parameter int unsigned NUM_FIELDS = 6,
   parameter int unsigned FIELD_W    = 8,
   parameter int unsigned ADDR_W     = 4
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          sec_tick,
   input  logic [NUM_FIELDS*FIELD_W-1:0] cal_time,
   input  logic                          wr_en,
   input  logic [ADDR_W-1:0]             addr,
   input  logic [FIELD_W-1:0]            wr_data,
   output logic [FIELD_W-1:0]            rd_data,
   output logic                          irq_n
);
   import alarm_cmp_pkg::*;

   localparam int unsigned EN_ADDR   = NUM_FIELDS;
   localparam int unsigned STAT_ADDR = NUM_FIELDS + 1;
   localparam int unsigned NUM_REGS  = NUM_FIELDS + 2;

   initial begin
      if (NUM_FIELDS < 1)
         $error("alarm_cmp_top: NUM_FIELDS must be at least 1");
      if ((FIELD_W % BCD_DIGIT_W) != 0)
         $error("alarm_cmp_top: FIELD_W must hold whole BCD digits");
      if ((2 ** ADDR_W) < NUM_REGS)
         $error("alarm_cmp_top: ADDR_W too small for the register set");
   end

   reg_sel_e                    sel;
   logic [NUM_FIELDS-1:0]       field_we;
   logic                        en_we;
   logic                        clr_req;
   logic                        hit;
   logic                        alarm_flag;
   logic                        irq_en;
   logic [NUM_FIELDS*FIELD_W-1:0] alarm_flat;

   always_comb begin
      if (addr < ADDR_W'(NUM_FIELDS))        sel = SEL_ALARM;
      else if (addr == ADDR_W'(EN_ADDR))     sel = SEL_ENABLE;
      else if (addr == ADDR_W'(STAT_ADDR))   sel = SEL_STATUS;
      else                                   sel = SEL_NONE;
   end

   always_comb begin
      for (int i = 0; i < NUM_FIELDS; i++)
         field_we[i] = wr_en && (sel == SEL_ALARM) && (addr == ADDR_W'(i));
   end

   assign en_we   = wr_en && (sel == SEL_ENABLE);
   assign clr_req = wr_en && (sel == SEL_STATUS) && wr_data[0];

   alarm_cmp_regs #(.NUM_FIELDS(NUM_FIELDS), .FIELD_W(FIELD_W)) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .field_we   (field_we),
      .en_we      (en_we),
      .wr_data    (wr_data),
      .alarm_flat (alarm_flat),
      .irq_en     (irq_en)
   );

   alarm_cmp_match #(.NUM_FIELDS(NUM_FIELDS), .FIELD_W(FIELD_W)) u_match (
      .alarm_flat (alarm_flat),
      .cal_flat   (cal_time),
      .all_eq     (hit)
   );

   alarm_cmp_status u_status (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_ev (sec_tick & hit),
      .clr_ev (clr_req),
      .irq_en (irq_en),
      .flag   (alarm_flag),
      .irq_n  (irq_n)
   );

   always_comb begin
      rd_data = '0;
      unique case (sel)
         SEL_ALARM: begin
            for (int i = 0; i < NUM_FIELDS; i++)
               if (addr == ADDR_W'(i)) rd_data = alarm_flat[i*FIELD_W +: FIELD_W];
         end
         SEL_ENABLE: rd_data = FIELD_W'(irq_en);
         SEL_STATUS: rd_data = FIELD_W'(alarm_flag);
         default:    rd_data = '0;
      endcase
   end
endmodule

// File: rtl/alarm_cmp_chk.sv
module alarm_cmp_chk (
   input logic clk,
   input logic rst_n,
   input logic tick,
   input logic match,
   input logic clr,
   input logic flag,
   input logic en,
   input logic irq_n
);
   p_set_on_match_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && match) |=> flag);

   p_hold_without_event_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!(tick && match) && !clr) |=> $stable(flag));

   p_no_irq_when_disabled_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !en |-> irq_n);

   p_irq_needs_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_n |-> flag);

   p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !(tick && match)) |=> !flag);

   p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && tick && match) |=> flag);
endmodule

bind alarm_cmp_top alarm_cmp_chk u_chk (
   .clk   (clk),
   .rst_n (rst_n),
   .tick  (sec_tick),
   .match (hit),
   .clr   (clr_req),
   .flag  (alarm_flag),
   .en    (irq_en),
   .irq_n (irq_n)
);

// File: tb/alarm_cmp_top_tb.sv
module alarm_cmp_top_tb;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sec_tick = 1'b0;
   logic [47:0] cal_time = '0;
   logic        wr_en = 1'b0;
   logic [3:0]  addr = '0;
   logic [7:0]  wr_data = '0;
   logic [7:0]  rd_data;
   logic        irq_n;

   int checks = 0;
   int failures = 0;

   int m_alarm [6];
   int m_en = 0;
   int m_flag = 0;
   int cal [6];

   always #(CLK_PERIOD/2) clk = ~clk;

   alarm_cmp_top u_dut (
      .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .cal_time(cal_time),
      .wr_en(wr_en), .addr(addr), .wr_data(wr_data), .rd_data(rd_data), .irq_n(irq_n)
   );

   function automatic int model_read(int a);
      if (a < 6) return m_alarm[a];
      if (a == 6) return m_en;
      if (a == 7) return m_flag;
      return 0;
   endfunction

   task automatic check(string tag, int act, int exp, string what);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   // one cycle: inputs are set, advance through posedge, update model, compare at negedge
   task automatic cyc(string tag);
      bit hit;
      for (int i = 0; i < 6; i++) cal_time[i*8 +: 8] = cal[i][7:0];
      @(posedge clk);
      hit = sec_tick;
      for (int i = 0; i < 6; i++) if (cal[i] != m_alarm[i]) hit = 0;
      if (rst_n) begin
         if (hit) m_flag = 1;
         else if (wr_en && addr == 7 && wr_data[0]) m_flag = 0;
         if (wr_en && addr < 6) m_alarm[addr] = wr_data;
         if (wr_en && addr == 6) m_en = wr_data[0];
      end
      @(negedge clk);
      check(tag, irq_n, (m_flag && m_en) ? 0 : 1, "irq_n");
      check(tag, rd_data, model_read(addr), $sformatf("rd_data@%0d", addr));
      wr_en = 0; sec_tick = 0;
   endtask

   task automatic wr(string tag, int a, int d);
      wr_en = 1; addr = a[3:0]; wr_data = d[7:0]; cyc(tag);
   endtask

   task automatic rd(string tag, int a);
      addr = a[3:0]; cyc(tag);
   endtask

   task automatic tick(string tag);
      sec_tick = 1; cyc(tag);
   endtask

   task automatic read_all(string tag);
      for (int a = 0; a < 16; a++) rd(tag, a);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      for (int i = 0; i < 6; i++) begin m_alarm[i] = 0; cal[i] = 0; end
      @(negedge clk); @(negedge clk);
      rst_n = 1;
      // R1 reset state, R10 unmapped reads
      read_all("R1");
      // R2 alarm write and readback: 08:15:30, day 21, month 06, year 24
      wr("R2", 0, 'h30); wr("R2", 1, 'h15); wr("R2", 2, 'h08);
      wr("R2", 3, 'h21); wr("R2", 4, 'h06); wr("R2", 5, 'h24);
      read_all("R2");
      cal[0]='h30; cal[1]='h15; cal[2]='h08; cal[3]='h21; cal[4]='h06; cal[5]='h24;
      // R4 equal calendar without strobe
      for (int k = 0; k < 3; k++) rd("R4", 7);
      // R4 one byte differs at each position
      for (int f = 0; f < 6; f++) begin
         cal[f] = cal[f] ^ 'h01;
         addr = 7; tick("R4");
         cal[f] = cal[f] ^ 'h01;
      end
      // R5 match with enable off
      addr = 7; tick("R5");
      rd("R5", 7); rd("R5", 6);
      // R6 enable on, level held without strobes
      wr("R6", 6, 'h01);
      for (int k = 0; k < 4; k++) rd("R6", 7);
      // R7 write 0 has no effect, write 1 clears
      wr("R7", 7, 'h00); rd("R7", 7);
      wr("R7", 7, 'hFE); rd("R7", 7);
      wr("R7", 7, 'h01); rd("R7", 7);
      // R8 match and clear in same cycle
      addr = 7; tick("R3");
      rd("R3", 7);
      wr_en = 1; addr = 7; wr_data = 'h01; sec_tick = 1; cyc("R8");
      rd("R8", 7);
      // R9 disable releases line, flag stays; re-arm
      wr("R9", 6, 'h00); rd("R9", 7); rd("R9", 6);
      wr("R9", 6, 'hFF); rd("R9", 6);
      wr("R9", 7, 'h01); rd("R9", 7);
      // R10 writes to unmapped addresses
      for (int a = 8; a < 16; a++) wr("R10", a, 'hFF);
      read_all("R10");
      // R4 / R3 upper limits: month 12 year 99
      wr("R2", 4, 'h12); wr("R2", 5, 'h99);
      cal[4]='h11; cal[5]='h99; addr = 7; tick("R4");
      cal[4]='h12; cal[5]='h98; addr = 7; tick("R4");
      cal[5]='h99; addr = 7; tick("R3");
      rd("R6", 7);
      wr("R7", 7, 'h01); rd("R7", 7);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule